// File: doc/BRIEF.md
# Synchronous Byte-Lane SRAM Core with Selectable Read Latency

This block is a behavioural synchronous static memory. It stores words split into byte lanes. A write can update any subset of those lanes, or every lane at once. Address, chip enable and write controls are sampled on the rising clock edge. A mode input sets the read path. It is either flow-through, where the word is shown right after the edge that samples the read, or pipelined, where one more output register adds a cycle.

Turning the output off is pipelined to the same depth as a read. A cycle with chip enable low, or a write cycle, removes the drive only after as many edges as a read takes to show its data. Output enable and the sleep input act on the output without waiting for a clock. While sleep is high, the stored contents are kept and every command is ignored.

Top module: `sync_sram_core`

## Requirements
- R1: While reset is held and after its release, before any read, `drive` is low and `rdata` is all zero.
- R2: With `pipe_mode` low, a read sampled at edge k (`ce` high, no write per R5 to R7) shows the word at `addr` with `drive` high from edge k until edge k+1.
- R3: With `pipe_mode` high, a read sampled at edge k shows nothing after edge k. It shows the word with `drive` high after edge k+1.
- R4: A cycle with `ce` low, or a write cycle, ends the drive after one edge in flow-through mode and after two edges in pipelined mode. In pipelined mode the previous read stays driven for the cycle in between.
- R5: With `bwe` high and `gwe` low, lane i (bits `wdata[i*LANE_W +: LANE_W]`, selected by `lane_we[i]`) is written for each set bit. All other lanes keep their contents.
- R6: `bwe` high with no `lane_we` bit set, or `lane_we` bits set with `bwe` low (and `gwe` low), writes nothing. Such a cycle is a read.
- R7: `gwe` high writes every lane, whatever `bwe` and `lane_we` are.
- R8: `oe` low forces `drive` low at once, with no clock edge. Raising it again restores a pending valid read at once.
- R9: `rdata` is all zero whenever `drive` is low.
- R10: While `sleep` is high, `drive` is low, commands are ignored and the read pipeline empties. Stored data survives, and the first cycle after `sleep` falls works normally.
- R11: A read after a write to the same address returns the written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the output pipeline |
| addr | input | ADDR_W | Word address |
| ce | input | 1 | Chip enable, high selects |
| bwe | input | 1 | Byte write enable |
| lane_we | input | LANES | Per-lane write selects |
| gwe | input | 1 | Global write, all lanes |
| wdata | input | LANES*LANE_W | Write data |
| pipe_mode | input | 1 | 1 = pipelined read path, 0 = flow-through |
| oe | input | 1 | Asynchronous output enable |
| sleep | input | 1 | Low-power request, high active |
| rdata | output | LANES*LANE_W | Read data, zero when not driven |
| drive | output | 1 | Output drive enable |

## Verification
In pipelined mode a write can be sampled in the same cycle that the output still shows an earlier read of the same address. The bench reads an address, writes new data to it on the very next edge, and expects the old word on the output during that cycle. It then expects one idle cycle and, after a fresh read, the new word. Output enable dropping in the middle of a valid read cycle is the second overlap: the bench expects `drive` and `rdata` to fall before any edge.

// File: rtl/sram_core_pkg.sv
package sram_core_pkg;

    typedef enum logic [1:0] {
        CMD_IDLE  = 2'd0,
        CMD_READ  = 2'd1,
        CMD_WRITE = 2'd2
    } sram_cmd_e;

endpackage

// File: rtl/sram_cmd_decode.sv
module sram_cmd_decode
    import sram_core_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             ce,
    input  logic             bwe,
    input  logic [LANES-1:0] lane_we,
    input  logic             gwe,
    input  logic             sleep,
    output sram_cmd_e        cmd,
    output logic [LANES-1:0] lane_mask
);

    logic any_write;

    always_comb begin
        any_write = gwe || (bwe && (|lane_we));
        lane_mask = gwe ? {LANES{1'b1}} : lane_we;
        if (sleep || !ce) begin
            cmd = CMD_IDLE;
        end else if (any_write) begin
            cmd = CMD_WRITE;
        end else begin
            cmd = CMD_READ;
        end
    end

endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array #(
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    parameter int ADDR_W = 4
) (
    input  logic                    clk,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    wr_en,
    input  logic                    rd_en,
    input  logic [LANES-1:0]        lane_mask,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rd_q
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        logic [LANE_W-1:0] rd_lane_q;

        always_ff @(posedge clk) begin
            if (wr_en && lane_mask[g]) begin
                mem[addr] <= wdata[g*LANE_W +: LANE_W];
            end
            if (rd_en) begin
                rd_lane_q <= mem[addr];
            end
        end

        assign rd_q[g*LANE_W +: LANE_W] = rd_lane_q;
    end

endmodule

// File: rtl/sram_out_stage.sv
module sram_out_stage #(
    parameter int W = 36
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rd_cmd,
    input  logic         sleep,
    input  logic         pipe_mode,
    input  logic         oe,
    input  logic [W-1:0] s1_data,
    output logic         drive,
    output logic [W-1:0] rdata
);

    typedef struct packed {
        logic         s1_v;
        logic         s2_v;
        logic [W-1:0] s2_data;
    } out_state_t;

    out_state_t st_d, st_q;
    logic       sel_v;
    logic [W-1:0] sel_data;

    always_comb begin
        st_d         = st_q;
        st_d.s1_v    = rd_cmd && !sleep;
        st_d.s2_v    = st_q.s1_v && !sleep;
        st_d.s2_data = s1_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        sel_v    = pipe_mode ? st_q.s2_v    : st_q.s1_v;
        sel_data = pipe_mode ? st_q.s2_data : s1_data;
        drive    = oe && sel_v && !sleep;
        rdata    = drive ? sel_data : '0;
    end

endmodule

// File: rtl/sync_sram_core.sv
module sync_sram_core
    import sram_core_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    parameter int ADDR_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    ce,
    input  logic                    bwe,
    input  logic [LANES-1:0]        lane_we,
    input  logic                    gwe,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic                    pipe_mode,
    input  logic                    oe,
    input  logic                    sleep,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    drive
);

    localparam int W = LANES * LANE_W;

    sram_cmd_e        cmd;
    logic [LANES-1:0] lane_mask;
    logic [W-1:0]     arr_q;

    sram_cmd_decode #(.LANES(LANES)) u_dec (
        .ce        (ce),
        .bwe       (bwe),
        .lane_we   (lane_we),
        .gwe       (gwe),
        .sleep     (sleep),
        .cmd       (cmd),
        .lane_mask (lane_mask)
    );

    sram_lane_array #(.LANES(LANES), .LANE_W(LANE_W), .ADDR_W(ADDR_W)) u_arr (
        .clk       (clk),
        .addr      (addr),
        .wr_en     (cmd == CMD_WRITE),
        .rd_en     (cmd == CMD_READ),
        .lane_mask (lane_mask),
        .wdata     (wdata),
        .rd_q      (arr_q)
    );

    sram_out_stage #(.W(W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_cmd    (cmd == CMD_READ),
        .sleep     (sleep),
        .pipe_mode (pipe_mode),
        .oe        (oe),
        .s1_data   (arr_q),
        .drive     (drive),
        .rdata     (rdata)
    );

endmodule

// File: rtl/sync_sram_core_chk.sv
module sync_sram_core_chk #(
    parameter int W = 36
) (
    input logic         clk,
    input logic         rst_n,
    input logic         ce,
    input logic         bwe,
    input logic         gwe,
    input logic         pipe_mode,
    input logic         oe,
    input logic         sleep,
    input logic         drive,
    input logic [W-1:0] rdata
);

    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> !drive); // R1

    AST_FLOW_READ_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && !gwe && !bwe && !pipe_mode && !sleep)
        |=> (pipe_mode || sleep || !oe || drive)); // R2

    AST_PIPE_READ_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && !gwe && !bwe && pipe_mode && !sleep) ##1 (pipe_mode && !sleep)
        |=> (!pipe_mode || sleep || !oe || drive)); // R3

    AST_FLOW_DESELECT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce && !pipe_mode) |=> (pipe_mode || !drive)); // R4

    AST_PIPE_DESELECT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce && pipe_mode) ##1 pipe_mode |=> (!pipe_mode || !drive)); // R4

    AST_OE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        !oe |-> !drive); // R8

    AST_UNDRIVEN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !drive |-> (rdata == '0)); // R9

    AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !drive); // R10

endmodule

bind sync_sram_core sync_sram_core_chk #(.W(LANES * LANE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce        (ce),
    .bwe       (bwe),
    .gwe       (gwe),
    .pipe_mode (pipe_mode),
    .oe        (oe),
    .sleep     (sleep),
    .drive     (drive),
    .rdata     (rdata)
);

// File: tb/test_sync_sram_core.sv
`timescale 1ns/1ps
module test_sync_sram_core;

    localparam int LANES  = 4;
    localparam int LANE_W = 9;
    localparam int ADDR_W = 4;
    localparam int W      = LANES * LANE_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic              ce = 1'b0;
    logic              bwe = 1'b0;
    logic [LANES-1:0]  lane_we = '0;
    logic              gwe = 1'b0;
    logic [W-1:0]      wdata = '0;
    logic              pipe_mode = 1'b0;
    logic              oe = 1'b1;
    logic              sleep = 1'b0;
    logic [W-1:0]      rdata;
    logic              drive;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    sync_sram_core #(.LANES(LANES), .LANE_W(LANE_W), .ADDR_W(ADDR_W)) i_sync_sram_core (
        .clk(clk), .rst_n(rst_n), .addr(addr), .ce(ce), .bwe(bwe),
        .lane_we(lane_we), .gwe(gwe), .wdata(wdata), .pipe_mode(pipe_mode),
        .oe(oe), .sleep(sleep), .rdata(rdata), .drive(drive)
    );

    task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    // One command: inputs set at the falling edge, result sampled 2 ns after the rising edge
    task automatic cyc(input logic c, input logic b, input logic [LANES-1:0] ln,
                       input logic g, input logic [W-1:0] d, input logic [ADDR_W-1:0] a);
        @(negedge clk);
        ce = c; bwe = b; lane_we = ln; gwe = g; wdata = d; addr = a;
        @(posedge clk);
        #2;
    endtask

    task automatic wr_all(input logic [ADDR_W-1:0] a, input logic [W-1:0] d);
        cyc(1'b1, 1'b0, '0, 1'b1, d, a);
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a);
        cyc(1'b1, 1'b0, '0, 1'b0, '0, a);
    endtask

    task automatic idle();
        cyc(1'b0, 1'b0, '0, 1'b0, '0, '0);
    endtask

    function automatic logic [W-1:0] merge(input logic [W-1:0] old, input logic [W-1:0] nw,
                                           input logic [LANES-1:0] m);
        logic [W-1:0] r = old;
        for (int i = 0; i < LANES; i++)
            if (m[i]) r[i*LANE_W +: LANE_W] = nw[i*LANE_W +: LANE_W];
        return r;
    endfunction

    task automatic t_reset();
        #5;
        chk("R1 drive in reset", W'(drive), W'(0));
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #2;
        chk("R1 drive after reset", W'(drive), W'(0));
        chk("R1 rdata after reset", rdata, '0);
    endtask

    task automatic t_flow();
        pipe_mode = 1'b0;
        wr_all(4'd3, 36'h123456789);
        rd(4'd3);
        chk("R2 flow drive", W'(drive), W'(1));
        chk("R2 R11 flow data", rdata, 36'h123456789);
        idle();
        chk("R4 flow deselect off", W'(drive), W'(0));
        chk("R9 zero when off", rdata, '0);
    endtask

    task automatic t_pipe();
        pipe_mode = 1'b1;
        wr_all(4'd5, 36'hABCDEF012);
        rd(4'd5);
        chk("R3 pipe no data after one edge", W'(drive), W'(0));
        idle();
        chk("R3 pipe drive", W'(drive), W'(1));
        chk("R3 pipe data", rdata, 36'hABCDEF012);
        idle();
        chk("R4 pipe deselect off after second edge", W'(drive), W'(0));
        // back-to-back reads
        wr_all(4'd6, 36'h111111111);
        rd(4'd5);
        rd(4'd6);
        chk("R3 stream first", rdata, 36'hABCDEF012);
        idle();
        chk("R3 stream second", rdata, 36'h111111111);
        idle();
    endtask

    task automatic t_bytes();
        logic [W-1:0] exp;
        pipe_mode = 1'b0;
        wr_all(4'd7, 36'h123456789);
        cyc(1'b1, 1'b1, 4'b0101, 1'b0, 36'hFFFFFFFFF, 4'd7);
        exp = merge(36'h123456789, 36'hFFFFFFFFF, 4'b0101);
        rd(4'd7);
        chk("R5 lanes 0 and 2 only", rdata, exp);
        cyc(1'b1, 1'b1, 4'b0000, 1'b0, 36'h000000000, 4'd7);
        chk("R6 bwe without lanes writes nothing", rdata, exp);
        cyc(1'b1, 1'b0, 4'b1111, 1'b0, 36'h000000000, 4'd7);
        chk("R6 lanes without bwe write nothing", rdata, exp);
        idle();
    endtask

    task automatic t_global();
        pipe_mode = 1'b0;
        cyc(1'b1, 1'b0, 4'b0000, 1'b1, 36'h0F0F0F0F0, 4'd8);
        rd(4'd8);
        chk("R7 gwe alone writes all", rdata, 36'h0F0F0F0F0);
        cyc(1'b1, 1'b1, 4'b0001, 1'b1, 36'h5A5A5A5A5, 4'd8);
        rd(4'd8);
        chk("R7 gwe overrides lanes", rdata, 36'h5A5A5A5A5);
        idle();
    endtask

    task automatic t_oe();
        pipe_mode = 1'b0;
        rd(4'd8);
        oe = 1'b0; #1;
        chk("R8 oe low drops drive", W'(drive), W'(0));
        chk("R9 oe low zero data", rdata, '0);
        oe = 1'b1; #1;
        chk("R8 oe high restores", rdata, 36'h5A5A5A5A5);
        idle();
    endtask

    task automatic t_sleep();
        pipe_mode = 1'b0;
        wr_all(4'd9, 36'h0000BEEF1);
        rd(4'd9);
        sleep = 1'b1; #1;
        chk("R10 sleep drops drive", W'(drive), W'(0));
        wr_all(4'd9, 36'h999999999);
        chk("R10 no drive in sleep", W'(drive), W'(0));
        @(negedge clk); sleep = 1'b0;
        ce = 1'b0; #1;
        chk("R10 pipeline emptied", W'(drive), W'(0));
        rd(4'd9);
        chk("R10 data retained", rdata, 36'h0000BEEF1);
        idle();
    endtask

    task automatic t_overlap();
        pipe_mode = 1'b1;
        wr_all(4'd2, 36'h222222222);
        rd(4'd2);
        wr_all(4'd2, 36'h333333333);
        chk("R4 old read shown during write", rdata, 36'h222222222);
        rd(4'd2);
        chk("R4 write cycle off after two edges", W'(drive), W'(0));
        idle();
        chk("R11 new word after write", rdata, 36'h333333333);
        idle();
    endtask

    initial begin
        t_reset();
        t_flow();
        t_pipe();
        t_bytes();
        t_global();
        t_oe();
        t_sleep();
        t_overlap();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule